// File: doc/BRIEF.md
# Two-Port Memory Tile with FIFO Mode

This block is one 256-word by 9-bit storage tile with a write port and a read port that can run in the same cycle. A static mode input selects how the tile is used. In addressed mode it is a plain two-port RAM. In queue mode it is a first-in first-out buffer. In queue mode the tile keeps its own pointers and reports empty, full and two occupancy thresholds that the caller programs.

Each port has its own timing select. A registered write port takes the request one clock later. A registered read port holds its output in a register. The unregistered forms act at the current edge, or show the word combinationally. The ninth bit can be filled in as a parity bit on the way in and checked on the way out, with either polarity. Several tiles are meant to be placed side by side or stacked by surrounding logic to build wider or deeper memories. This tile models only one element.

Top module: `fifo_sram_tile`

## Requirements
- R1: With `fifo_mode`=0, an accepted write stores the 9-bit word at `wr_addr` and a read targets `rd_addr`. A read and a write in the same cycle are both served. When they hit the same address, the read returns the word held before that write.
- R2: With `wr_sync`=0 a write is committed at the clock edge where `wr_en` is sampled high. With `wr_sync`=1 the request (enable, address, data) is registered and committed at the following edge.
- R3: With `rd_sync`=1, `rd_data` is a register that reset clears to 0. It loads the target word at an edge where a read is accepted and holds its value otherwise. With `rd_sync`=0, `rd_data` shows the target word combinationally.
- R4: With `fifo_mode`=1, `wr_addr` and `rd_addr` are ignored. Words come out in the order they were written. The target of a read is the oldest stored word.
- R5: Queue occupancy ranges from 0 to 256. `empty` is 1 exactly when it is 0, and `full` is 1 exactly when it is 256. After reset `empty`=1 and `full`=0.
- R6: `almost_empty` is 1 when occupancy <= `ae_level`. `almost_full` is 1 when occupancy >= `af_level`. Both levels are unsigned 8-bit values.
- R7: In queue mode a write that meets `full`=1 at its commit edge is dropped. It leaves contents and occupancy unchanged, and it sets `overflow`. `overflow` stays set until reset.
- R8: In queue mode a read with `empty`=1 is dropped. It leaves `rd_data` and occupancy unchanged, and it sets `underflow`. `underflow` stays set until reset.
- R9: With `par_gen_en`=1, bit 8 of the committed word is the XOR of bits 7:0, inverted when `par_odd`=1. With `par_gen_en`=0, all 9 bits are stored as given.
- R10: With `par_chk_en`=1, an accepted read of a word whose 9-bit XOR differs from `par_odd` raises `par_err`. The flag is high during the read cycle when `rd_sync`=0, and in the cycle after the read edge when `rd_sync`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_mode | input | 1 | 1 = queue mode, 0 = addressed mode |
| wr_sync | input | 1 | 1 = registered write port |
| rd_sync | input | 1 | 1 = registered read port |
| par_gen_en | input | 1 | Generate parity into bit 8 on write |
| par_chk_en | input | 1 | Check parity on accepted reads |
| par_odd | input | 1 | Parity polarity, 1 = odd |
| ae_level | input | 8 | Almost-empty threshold |
| af_level | input | 8 | Almost-full threshold |
| wr_en | input | 1 | Write request |
| wr_addr | input | 8 | Write address (addressed mode) |
| wr_data | input | 9 | Write word |
| rd_en | input | 1 | Read request |
| rd_addr | input | 8 | Read address (addressed mode) |
| rd_data | output | 9 | Read word |
| par_err | output | 1 | Parity error pulse |
| empty | output | 1 | Queue empty |
| full | output | 1 | Queue full |
| almost_empty | output | 1 | Occupancy at or below threshold |
| almost_full | output | 1 | Occupancy at or above threshold |
| overflow | output | 1 | Sticky dropped-write flag |
| underflow | output | 1 | Sticky dropped-read flag |

## Verification
Some checks hold on every cycle. The assertions test that empty and full never coincide, that the threshold flags agree with the two extremes, and that the error flags are sticky. They also check that a full queue with no read stays full, that an empty queue with no write stays empty, and that a registered read port holds when idle. Other behaviour depends on history, and only the bench's reference model can show it. That covers read-before-write on a shared address, the one-cycle shift of a registered write, queue order across pointer wrap, dropped accesses leaving contents intact, and the parity bit and error timing under both polarities and both read timings.

// File: rtl/tile_pkg.sv
// Shared definitions for the memory tile.
// Assumes: a single clock domain and a tile of 2**ADDR_W words.
package tile_pkg;
    typedef enum logic {
        PORT_COMB = 1'b0,
        PORT_REG  = 1'b1
    } port_timing_e;

    localparam int TILE_ADDR_W = 8;
    localparam int TILE_DATA_W = 9;
endpackage

// File: rtl/tile_wr_stage.sv
// Write-side front end: optionally delays the write request by one
// register stage and fills in the parity bit (top bit) on the way out.
// Assumes: wr_sync is static in normal use; parity uses bits DATA_W-2:0.
module tile_wr_stage #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sync,
    input  logic              gen_en,
    input  logic              par_odd,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              eff_we,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [DATA_W-1:0] eff_data
);
    import tile_pkg::*;

    localparam int PAY_W = DATA_W - 1;

    logic              pend_vld;
    logic [ADDR_W-1:0] pend_addr;
    logic [DATA_W-1:0] pend_data;
    logic [DATA_W-1:0] raw_data;

    // Capture the live request for the registered write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld  <= 1'b0;
            pend_addr <= '0;
            pend_data <= '0;
        end else begin
            pend_vld  <= wr_en;
            pend_addr <= wr_addr;
            pend_data <= wr_data;
        end
    end

    // Select the live or delayed request and apply parity generation.
    always_comb begin
        if (port_timing_e'(wr_sync) == PORT_REG) begin
            eff_we   = pend_vld;
            eff_addr = pend_addr;
            raw_data = pend_data;
        end else begin
            eff_we   = wr_en;
            eff_addr = wr_addr;
            raw_data = wr_data;
        end
        eff_data = raw_data;
        if (gen_en) begin
            eff_data[DATA_W-1] = (^raw_data[PAY_W-1:0]) ^ par_odd;
        end
    end
endmodule

// File: rtl/tile_fifo_ctl.sv
// Queue controller: wrap-bit pointers, occupancy flags, access gating
// and sticky drop flags. In addressed mode every request passes through
// and the pointers stay put.
// Assumes: fifo_mode is static between resets.
module tile_fifo_ctl #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_mode,
    input  logic              we_req,
    input  logic              re_req,
    input  logic [ADDR_W-1:0] ae_level,
    input  logic [ADDR_W-1:0] af_level,
    output logic              we_ok,
    output logic              re_ok,
    output logic [ADDR_W-1:0] wptr,
    output logic [ADDR_W-1:0] rptr,
    output logic              empty,
    output logic              full,
    output logic              almost_empty,
    output logic              almost_full,
    output logic              overflow,
    output logic              underflow
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0] wp_q;
    logic [PW-1:0] rp_q;
    logic [PW-1:0] occ;

    // Derive occupancy and the four level flags from the pointers.
    always_comb begin
        occ          = wp_q - rp_q;
        empty        = (wp_q == rp_q);
        full         = (wp_q[ADDR_W-1:0] == rp_q[ADDR_W-1:0]) &&
                       (wp_q[ADDR_W] != rp_q[ADDR_W]);
        almost_empty = (occ <= {1'b0, ae_level});
        almost_full  = (occ >= {1'b0, af_level});
        we_ok        = we_req && !(fifo_mode && full);
        re_ok        = re_req && !(fifo_mode && empty);
        wptr         = wp_q[ADDR_W-1:0];
        rptr         = rp_q[ADDR_W-1:0];
    end

    // Advance pointers on accepted accesses and latch drop events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q      <= '0;
            rp_q      <= '0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else if (fifo_mode) begin
            if (we_ok) wp_q <= wp_q + 1'b1;
            if (re_ok) rp_q <= rp_q + 1'b1;
            if (we_req && !we_ok) overflow  <= 1'b1;
            if (re_req && !re_ok) underflow <= 1'b1;
        end
    end
endmodule

// File: rtl/tile_store.sv
// Storage array: one synchronous write port and one combinational read
// port. A read of the address being written shows the old word until
// the edge.
// Assumes: no reset of contents.
module tile_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Commit one word per clock.
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    // Present the addressed word.
    assign rdata = cells[raddr];
endmodule

// File: rtl/fifo_sram_tile.sv
// Top of the memory tile: joins the write stage, queue controller and
// storage, and builds the read-side timing and parity checking.
// Assumes: mode and timing selects are static between resets.
module fifo_sram_tile #(
    parameter int ADDR_W = tile_pkg::TILE_ADDR_W,
    parameter int DATA_W = tile_pkg::TILE_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_mode,
    input  logic              wr_sync,
    input  logic              rd_sync,
    input  logic              par_gen_en,
    input  logic              par_chk_en,
    input  logic              par_odd,
    input  logic [ADDR_W-1:0] ae_level,
    input  logic [ADDR_W-1:0] af_level,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              par_err,
    output logic              empty,
    output logic              full,
    output logic              almost_empty,
    output logic              almost_full,
    output logic              overflow,
    output logic              underflow
);
    import tile_pkg::*;

    logic              eff_we;
    logic [ADDR_W-1:0] eff_addr;
    logic [DATA_W-1:0] eff_data;
    logic              we_ok;
    logic              re_ok;
    logic [ADDR_W-1:0] fwp;
    logic [ADDR_W-1:0] frp;
    logic [ADDR_W-1:0] mem_waddr;
    logic [ADDR_W-1:0] mem_raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic [DATA_W-1:0] rd_q;
    logic              perr_q;
    logic              word_bad;

    tile_wr_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sync  (wr_sync),
        .gen_en   (par_gen_en),
        .par_odd  (par_odd),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .eff_we   (eff_we),
        .eff_addr (eff_addr),
        .eff_data (eff_data)
    );

    tile_fifo_ctl #(.ADDR_W(ADDR_W)) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_mode    (fifo_mode),
        .we_req       (eff_we),
        .re_req       (rd_en),
        .ae_level     (ae_level),
        .af_level     (af_level),
        .we_ok        (we_ok),
        .re_ok        (re_ok),
        .wptr         (fwp),
        .rptr         (frp),
        .empty        (empty),
        .full         (full),
        .almost_empty (almost_empty),
        .almost_full  (almost_full),
        .overflow     (overflow),
        .underflow    (underflow)
    );

    // Pick array addresses from the pointers or from the ports.
    always_comb begin
        mem_waddr = fifo_mode ? fwp : eff_addr;
        mem_raddr = fifo_mode ? frp : rd_addr;
    end

    tile_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .we    (we_ok),
        .waddr (mem_waddr),
        .wdata (eff_data),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    // Flag a target word whose parity disagrees with the chosen polarity.
    assign word_bad = par_chk_en && ((^mem_rdata) != par_odd);

    // Registered read port: load on accepted reads, time the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= '0;
            perr_q <= 1'b0;
        end else begin
            perr_q <= rd_sync && re_ok && word_bad;
            if (rd_sync && re_ok) rd_q <= mem_rdata;
        end
    end

    // Choose registered or combinational read presentation.
    always_comb begin
        if (port_timing_e'(rd_sync) == PORT_REG) begin
            rd_data = rd_q;
            par_err = perr_q;
        end else begin
            rd_data = mem_rdata;
            par_err = re_ok && word_bad;
        end
    end
endmodule

// File: rtl/tile_checker.sv
// Cycle-level properties of the memory tile, bound to every instance.
module tile_checker #(
    parameter int DATA_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_mode,
    input logic              wr_sync,
    input logic              rd_sync,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              empty,
    input logic              full,
    input logic              almost_empty,
    input logic              almost_full,
    input logic              overflow,
    input logic              underflow
);
    a_r5_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

    a_r6_empty_is_low: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> almost_empty);

    a_r6_full_is_high: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> almost_full);

    a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    a_r8_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

    a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode && full && !rd_en) |=> full);

    a_r8_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode && empty && !wr_en && !wr_sync) |=> empty);

    a_r3_reg_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sync && !rd_en) |=> (!rd_sync || $stable(rd_data)));
endmodule

bind fifo_sram_tile tile_checker #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_mode    (fifo_mode),
    .wr_sync      (wr_sync),
    .rd_sync      (rd_sync),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .rd_data      (rd_data),
    .empty        (empty),
    .full         (full),
    .almost_empty (almost_empty),
    .almost_full  (almost_full),
    .overflow     (overflow),
    .underflow    (underflow)
);

// File: tb/sim_fifo_sram_tile.sv
`timescale 1ns/1ps
module sim_fifo_sram_tile;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_mode = 1'b0, wr_sync = 1'b0, rd_sync = 1'b1;
    logic       par_gen_en = 1'b0, par_chk_en = 1'b0, par_odd = 1'b0;
    logic [7:0] ae_level = 8'd0, af_level = 8'd255;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_addr = 8'd0, rd_addr = 8'd0;
    logic [8:0] wr_data = 9'd0;
    logic [8:0] rd_data;
    logic       par_err, empty, full, almost_empty, almost_full, overflow, underflow;

    int  errors = 0;
    int  checks = 0;
    bit  done = 0;

    // Behavioural reference state
    int  mem [256];
    int  wp, rp, rdq;
    bit  ov, un, pq, pv;
    int  pa, pd;
    int  seed = 32'h1d2c3b4a;

    always #2.5 clk = ~clk;

    fifo_sram_tile u0 (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .wr_sync(wr_sync),
        .rd_sync(rd_sync), .par_gen_en(par_gen_en), .par_chk_en(par_chk_en),
        .par_odd(par_odd), .ae_level(ae_level), .af_level(af_level),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .par_err(par_err), .empty(empty),
        .full(full), .almost_empty(almost_empty), .almost_full(almost_full),
        .overflow(overflow), .underflow(underflow)
    );

    function automatic int xor9(int w);
        int p = 0;
        for (int i = 0; i < 9; i++) p ^= (w >> i) & 1;
        return p;
    endfunction

    function automatic int occ();
        return (wp - rp + 512) % 512;
    endfunction

    function automatic int tgt();
        return fifo_mode ? mem[rp % 256] : mem[rd_addr];
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Advance the reference by one clock edge using the current inputs.
    task automatic model_edge();
        int we, a, d, cnt, wacc, racc, word;
        if (!rst_n) begin
            wp = 0; rp = 0; ov = 0; un = 0; rdq = 0; pq = 0; pv = 0; pa = 0; pd = 0;
            return;
        end
        cnt = occ();
        if (wr_sync) begin we = pv; a = pa; d = pd; end
        else begin we = wr_en; a = wr_addr; d = wr_data; end
        if (par_gen_en) d = (d & 255) | ((xor9(d & 255) ^ par_odd) << 8);
        wacc = we && (!fifo_mode || cnt < 256);
        racc = rd_en && (!fifo_mode || cnt > 0);
        word = tgt();
        pq = 0;
        if (rd_sync) begin
            if (racc) rdq = word;
            pq = racc && par_chk_en && word >= 0 && (xor9(word) != par_odd);
        end
        if (wacc) mem[fifo_mode ? wp % 256 : a] = d;
        if (fifo_mode) begin
            if (wacc) wp = (wp + 1) % 512;
            if (racc) rp = (rp + 1) % 512;
            if (we && !wacc) ov = 1;
            if (rd_en && !racc) un = 1;
        end
        pv = wr_en; pa = wr_addr; pd = wr_data;
    endtask

    // Compare every output with the reference, away from the edge.
    task automatic compare();
        int cnt, exp_rd, exp_pe, word;
        string rtag;
        cnt = occ();
        word = tgt();
        check("R5 empty", empty, cnt == 0);
        check("R5 full", full, cnt == 256);
        check("R6 almost_empty", almost_empty, cnt <= ae_level);
        check("R6 almost_full", almost_full, cnt >= af_level);
        check("R7 overflow", overflow, ov);
        check("R8 underflow", underflow, un);
        exp_rd = rd_sync ? rdq : word;
        rtag = fifo_mode ? "R4 rd_data" : "R3 rd_data";
        if (exp_rd >= 0) check(rtag, rd_data, exp_rd);
        if (rd_sync) exp_pe = pq;
        else exp_pe = par_chk_en && rd_en && (!fifo_mode || cnt > 0) &&
                      word >= 0 && (xor9(word) != par_odd);
        check("R10 par_err", par_err, exp_pe);
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic drive(bit we, int wa, int wd, bit re, int ra);
        wr_en = we; wr_addr = 8'(wa); wr_data = 9'(wd);
        rd_en = re; rd_addr = 8'(ra);
        tick();
    endtask

    task automatic do_reset();
        rst_n = 0; wr_en = 0; rd_en = 0;
        tick(); tick();
        rst_n = 1;
    endtask

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 8) & 32'h7fffffff;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        for (int i = 0; i < 256; i++) mem[i] = -1;
        @(negedge clk);
        do_reset();
        // R5: reset state, queue empty and not full, registered read at 0
        check("R5 reset empty", empty, 1);
        check("R5 reset full", full, 0);
        check("R3 reset rd_data", rd_data, 0);

        // R1 R9: fill every address, live write port, even parity generated
        par_gen_en = 1;
        for (int i = 0; i < 256; i++) drive(1, i, (i * 37 + 5) & 511, 0, 0);
        // R3: registered reads, then idle hold
        for (int i = 0; i < 16; i++) drive(0, 0, 0, 1, i * 16 + 3);
        drive(0, 0, 0, 0, 9);
        // R1: same-address read and write returns the old word
        drive(1, 7, 9'h0aa, 1, 7);
        drive(0, 0, 0, 1, 7);
        // R3: combinational reads with concurrent writes, including collisions
        rd_sync = 0;
        for (int i = 0; i < 24; i++) drive(1, i % 6, rnd(), 1, (i + 2) % 6);
        for (int i = 0; i < 8; i++) drive(1, 40 + i, rnd(), 1, 40 + i);
        // R2: registered write port shifts commits by one edge
        wr_sync = 1;
        for (int i = 0; i < 20; i++) drive(i % 3 != 0, 60 + (i % 5), rnd(), 1, 60 + ((i + 1) % 5));
        drive(0, 0, 0, 1, 61);
        drive(0, 0, 0, 1, 62);
        wr_sync = 0;
        // R9 R10: raw writes with bad parity, checked under both polarities and timings
        par_gen_en = 0; par_chk_en = 1;
        drive(1, 3, 9'h001, 0, 0);
        drive(1, 4, 9'h003, 0, 0);
        for (int pol = 0; pol < 2; pol++) begin
            par_odd = pol[0];
            for (int s = 0; s < 2; s++) begin
                rd_sync = s[0];
                drive(0, 0, 0, 1, 3);
                drive(0, 0, 0, 1, 4);
                drive(0, 0, 0, 0, 4);
            end
        end
        // R9: odd parity generation, verified by reading back the stored bit 8
        par_gen_en = 1; par_odd = 1;
        for (int i = 0; i < 8; i++) drive(1, 100 + i, rnd(), 0, 0);
        for (int i = 0; i < 8; i++) drive(0, 0, 0, 1, 100 + i);
        par_gen_en = 0; par_chk_en = 0; par_odd = 0;

        // R4 R5 R6 R7 R8: queue mode, registered read, live write
        fifo_mode = 1; rd_sync = 1; ae_level = 8'd3; af_level = 8'd250;
        do_reset();
        for (int i = 0; i < 258; i++) drive(1, 255 - (i % 256), i, 0, 0);
        drive(1, 0, 9'h155, 1, 0);
        for (int i = 0; i < 258; i++) drive(0, 0, 0, 1, i % 256);
        for (int i = 0; i < 300; i++) drive(rnd() % 3 != 0, rnd(), rnd(), rnd() % 2 == 0, rnd());
        // R4 R2: queue mode, registered write, combinational read, parity on
        wr_sync = 1; rd_sync = 0; par_gen_en = 1; par_chk_en = 1;
        ae_level = 8'd0; af_level = 8'd1;
        do_reset();
        for (int i = 0; i < 600; i++) drive(rnd() % 4 != 0, rnd(), rnd(), rnd() % 3 == 0, rnd());
        for (int i = 0; i < 300; i++) drive(0, 0, 0, 1, 0);
        for (int i = 0; i < 400; i++) drive(rnd() % 2 == 0, 0, rnd(), rnd() % 2 == 0, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule